// File: doc/BRIEF.md
# Register-Immediate Arithmetic Logic Unit with Coded Compare

This block is the 16-bit execute stage for a small processor with eight general registers. Each accepted operation combines the first operand `rx` with a second operand, then writes the result back into `rx`. The second operand is either the register value `ry` or a zero-extended immediate. Eight operations are available in both forms: add, subtract, and, or, xor, shift left, shift right and compare.

Compare does not set status flags. It writes a small code into the destination: 0 when the operands are equal, 1 when `rx` is greater and 2 when `rx` is less. Every accepted operation also produces the same code on a separate output, so a branch unit can use it as its condition flags. Shift amounts are variable and come from `ry` or from the immediate.

The register file and instruction decode are outside this block. The register file supplies `rx` and `ry`. It samples `result` as write data whenever `wr_en` is high and writes it into `rx`. When `OUT_REG` is 1, which is the default, the outputs are registered and hold their value between accepted operations.

Top module: `rx_alu`

## Requirements
- R1: While `rst_n` is low, `result`, `wr_en` and `cmp_code` are all zero.
- R2: Add (op 0) gives `rx + operand` and subtract (op 1) gives `rx - operand`. Both wrap modulo 2^16 and produce no carry.
- R3: The bitwise operations are and (op 2), or (op 3) and xor (op 4), each applied between `rx` and the operand.
- R4: Shift left (op 5) and shift right (op 6) move `rx` by `operand` bit positions and fill the vacated bits with zeros. An amount of `DATA_W` or more gives zero.
- R5: Compare (op 7) is unsigned. It writes 0 when `rx` equals the operand, 1 when `rx` is greater and 2 when `rx` is less, zero-extended to `DATA_W` bits.
- R6: With `use_imm` = 1, the operand is `imm_val` zero-extended to `DATA_W` bits. With `use_imm` = 0, the operand is `ry_val`.
- R7: An operation accepted with `in_valid` high at a clock edge appears on `result`, and `wr_en` is high, for exactly the cycle that follows that edge.
- R8: A cycle with `in_valid` low leaves `result` and `cmp_code` unchanged and drives `wr_en` low, whatever the other inputs are.
- R9: For every accepted operation, `cmp_code` carries the unsigned compare of `rx` against the operand, using the R5 encoding. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operation on this edge |
| op | input | 3 | Operation select (0 add ... 7 compare) |
| use_imm | input | 1 | 1 selects the immediate, 0 selects `ry_val` |
| rx_val | input | 16 | First operand, also the destination register value |
| ry_val | input | 16 | Register second operand |
| imm_val | input | IMM_W (8) | Immediate operand, zero-extended |
| result | output | 16 | Value to write back into `rx` |
| wr_en | output | 1 | Write-back strobe for `result` |
| cmp_code | output | 2 | Compare code for branch conditions |

## Verification
The bench builds the block with `DATA_W` = 16, `IMM_W` = 5 and the staged shifter. With a 5-bit immediate, immediate shift amounts reach 16 to 31, so the saturating-to-zero case can be driven from both operand sources. The narrow immediate also makes zero-extension visible in the and and compare results. Random operations run against a bench model, mixed with directed cases: wrap-around at 0xFFFF and at 0, shifts by exactly 15 and 16, and equal/greater/less compares. Idle cycles with changing inputs check that the outputs hold.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;

   localparam int OP_W  = 3;
   localparam int CMP_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_SHL = 3'd5,
      OP_SHR = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   typedef enum logic [CMP_W-1:0] {
      CMP_EQ = 2'd0,
      CMP_GT = 2'd1,
      CMP_LT = 2'd2
   } cmp_code_e;

endpackage

// File: rtl/rx_alu_operand.sv
module rx_alu_operand #(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 8
) (
   input  logic              use_imm,
   input  logic [DATA_W-1:0] ry_val,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [DATA_W-1:0] operand
);

   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (PAD_W == 0) begin : g_full_imm
         assign imm_ext = imm_val;
      end else begin : g_pad_imm
         assign imm_ext = {{PAD_W{1'b0}}, imm_val};
      end
   endgenerate

   assign operand = use_imm ? imm_ext : ry_val;

endmodule

// File: rtl/rx_alu_shifter.sv
module rx_alu_shifter #(
   parameter int DATA_W      = 16,
   parameter int SHIFT_STYLE = 0
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] amount,
   input  logic              dir_right,
   output logic [DATA_W-1:0] shifted
);

   localparam int AMT_W = $clog2(DATA_W);

   logic              too_far;
   logic [DATA_W-1:0] core;

   assign too_far = |amount[DATA_W-1:AMT_W];

   generate
      if (SHIFT_STYLE == 0) begin : g_staged
         logic [DATA_W-1:0] stage [0:AMT_W];
         assign stage[0] = value;
         for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            logic [DATA_W-1:0] moved;
            assign moved = dir_right ? (stage[s] >> STEP) : (stage[s] << STEP);
            assign stage[s+1] = amount[s] ? moved : stage[s];
         end
         assign core = stage[AMT_W];
      end else begin : g_operator
         logic [AMT_W-1:0] low_amt;
         assign low_amt = amount[AMT_W-1:0];
         assign core = dir_right ? (value >> low_amt) : (value << low_amt);
      end
   endgenerate

   assign shifted = too_far ? '0 : core;

endmodule

// File: rtl/rx_alu_compare.sv
module rx_alu_compare #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [1:0]        code
);

   import rx_alu_pkg::*;

   always_comb begin
      if (lhs == rhs)
         code = CMP_EQ;
      else if (lhs > rhs)
         code = CMP_GT;
      else
         code = CMP_LT;
   end

endmodule

// File: rtl/rx_alu.sv
module rx_alu #(
   parameter int DATA_W      = 16,
   parameter int IMM_W       = 8,
   parameter int SHIFT_STYLE = 0,
   parameter int OUT_REG     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] rx_val,
   input  logic [DATA_W-1:0] ry_val,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic [1:0]        cmp_code
);

   import rx_alu_pkg::*;

   localparam int CODE_PAD = DATA_W - CMP_W;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("rx_alu: DATA_W must be at least 4");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("rx_alu: IMM_W must lie in 1..DATA_W");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_bad_shift
         $error("rx_alu: SHIFT_STYLE must be 0 or 1");
      end
      if (OUT_REG < 0 || OUT_REG > 1) begin : g_bad_reg
         $error("rx_alu: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] shl_v;
   logic [DATA_W-1:0] shr_v;
   logic [DATA_W-1:0] next_res;
   logic [1:0]        next_code;

   rx_alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
      .use_imm (use_imm),
      .ry_val  (ry_val),
      .imm_val (imm_val),
      .operand (operand)
   );

   rx_alu_shifter #(.DATA_W(DATA_W), .SHIFT_STYLE(SHIFT_STYLE)) u_shl (
      .value     (rx_val),
      .amount    (operand),
      .dir_right (1'b0),
      .shifted   (shl_v)
   );

   rx_alu_shifter #(.DATA_W(DATA_W), .SHIFT_STYLE(SHIFT_STYLE)) u_shr (
      .value     (rx_val),
      .amount    (operand),
      .dir_right (1'b1),
      .shifted   (shr_v)
   );

   rx_alu_compare #(.DATA_W(DATA_W)) u_cmp (
      .lhs  (rx_val),
      .rhs  (operand),
      .code (next_code)
   );

   always_comb begin
      case (op)
         OP_ADD:  next_res = rx_val + operand;
         OP_SUB:  next_res = rx_val - operand;
         OP_AND:  next_res = rx_val & operand;
         OP_OR:   next_res = rx_val | operand;
         OP_XOR:  next_res = rx_val ^ operand;
         OP_SHL:  next_res = shl_v;
         OP_SHR:  next_res = shr_v;
         default: next_res = {{CODE_PAD{1'b0}}, next_code};
      endcase
   end

   generate
      if (OUT_REG == 1) begin : g_registered
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result   <= '0;
               wr_en    <= 1'b0;
               cmp_code <= '0;
            end else begin
               wr_en <= in_valid;
               if (in_valid) begin
                  result   <= next_res;
                  cmp_code <= next_code;
               end
            end
         end
      end else begin : g_direct
         assign result   = next_res;
         assign wr_en    = in_valid;
         assign cmp_code = next_code;
      end
   endgenerate

endmodule

// File: rtl/rx_alu_checker.sv
module rx_alu_checker #(
   parameter int DATA_W  = 16,
   parameter int IMM_W   = 8,
   parameter int OUT_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        op,
   input logic              use_imm,
   input logic [DATA_W-1:0] rx_val,
   input logic [DATA_W-1:0] ry_val,
   input logic [IMM_W-1:0]  imm_val,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [1:0]        cmp_code
);

   logic [DATA_W-1:0] opnd_c;
   assign opnd_c = use_imm ? DATA_W'(imm_val) : ry_val;

   generate
      if (OUT_REG == 1) begin : g_chk
         assert_wr_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> wr_en);

         assert_wr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !wr_en);

         assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(result) && $stable(cmp_code)));

         assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (cmp_code != 2'd3));

         assert_cmp_writes_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd7) |=> (result == DATA_W'(cmp_code)));

         assert_cmp_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd7 && rx_val == opnd_c) |=> (result == '0));

         assert_shift_far_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (op == 3'd5 || op == 3'd6) && opnd_c >= DATA_W) |=> (result == '0));
      end
   endgenerate

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R1: assert (result == '0 && wr_en == 1'b0 && cmp_code == '0);
      end
   end

endmodule

bind rx_alu rx_alu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OUT_REG(OUT_REG)) u_rx_alu_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .use_imm  (use_imm),
   .rx_val   (rx_val),
   .ry_val   (ry_val),
   .imm_val  (imm_val),
   .result   (result),
   .wr_en    (wr_en),
   .cmp_code (cmp_code)
);

// File: tb/rx_alu_bench.sv
module rx_alu_bench;

   localparam int DW = 16;
   localparam int IW = 5;
   localparam int WATCHDOG_CYCLES = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    op = '0;
   logic          use_imm = 1'b0;
   logic [DW-1:0] rx_val = '0;
   logic [DW-1:0] ry_val = '0;
   logic [IW-1:0] imm_val = '0;
   logic [DW-1:0] result;
   logic          wr_en;
   logic [1:0]    cmp_code;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   rx_alu #(.DATA_W(DW), .IMM_W(IW), .SHIFT_STYLE(0), .OUT_REG(1)) u_rx_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op       (op),
      .use_imm  (use_imm),
      .rx_val   (rx_val),
      .ry_val   (ry_val),
      .imm_val  (imm_val),
      .result   (result),
      .wr_en    (wr_en),
      .cmp_code (cmp_code)
   );

   function automatic logic [1:0] model_code(logic [DW-1:0] a, logic [DW-1:0] b);
      if (a == b) return 2'd0;
      if (a > b)  return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic [DW-1:0] model_res(logic [2:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
      case (o)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return (b >= DW) ? '0 : (a << b);
         3'd6: return (b >= DW) ? '0 : (a >> b);
         default: return {14'd0, model_code(a, b)};
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] o);
      case (o)
         3'd0, 3'd1: return "R2";
         3'd2, 3'd3, 3'd4: return "R3";
         3'd5, 3'd6: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(logic [2:0] o, logic imm_sel, logic [DW-1:0] a,
                         logic [DW-1:0] b, logic [IW-1:0] im, string req);
      logic [DW-1:0] opnd;
      opnd     = imm_sel ? DW'(im) : b;
      in_valid = 1'b1;
      op       = o;
      use_imm  = imm_sel;
      rx_val   = a;
      ry_val   = b;
      imm_val  = im;
      @(negedge clk);
      check(req, "result", result, model_res(o, a, opnd));
      check("R7", "wr_en", DW'(wr_en), DW'(1'b1));
      check("R9", "cmp_code", DW'(cmp_code), DW'(model_code(a, opnd)));
   endtask

   task automatic idle_cycle();
      logic [DW-1:0] r_keep;
      logic [1:0]    c_keep;
      r_keep   = result;
      c_keep   = cmp_code;
      in_valid = 1'b0;
      op       = 3'($urandom);
      use_imm  = 1'($urandom);
      rx_val   = 16'($urandom);
      ry_val   = 16'($urandom);
      imm_val  = 5'($urandom);
      @(negedge clk);
      check("R8", "held result", result, r_keep);
      check("R8", "held cmp_code", DW'(cmp_code), DW'(c_keep));
      check("R8", "wr_en low", DW'(wr_en), '0);
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0107));
      rst_n = 1'b0;
      in_valid = 1'b1;
      rx_val = 16'hFFFF;
      repeat (3) @(negedge clk);
      check("R1", "reset result", result, '0);
      check("R1", "reset wr_en", DW'(wr_en), '0);
      check("R1", "reset cmp_code", DW'(cmp_code), '0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R2 wrap-around in both directions
      run_op(3'd0, 1'b0, 16'hFFFF, 16'h0001, '0, "R2");
      run_op(3'd1, 1'b0, 16'h0000, 16'h0001, '0, "R2");
      run_op(3'd1, 1'b1, 16'h0003, 16'h0000, 5'd7, "R2");
      // R3 logic with both operand sources
      run_op(3'd2, 1'b0, 16'hF0F0, 16'h3C3C, '0, "R3");
      run_op(3'd3, 1'b1, 16'h8000, 16'hFFFF, 5'h15, "R3");
      run_op(3'd4, 1'b0, 16'hAAAA, 16'hFFFF, '0, "R3");
      // R6 immediate zero-extension: top bits of rx cleared
      run_op(3'd2, 1'b1, 16'hFFFF, 16'hFFFF, 5'h1F, "R6");
      run_op(3'd7, 1'b1, 16'h001F, 16'h0000, 5'h1F, "R6");
      // R4 shift boundaries
      run_op(3'd5, 1'b1, 16'h0001, '0, 5'd15, "R4");
      run_op(3'd5, 1'b1, 16'h0001, '0, 5'd16, "R4");
      run_op(3'd6, 1'b1, 16'h8000, '0, 5'd15, "R4");
      run_op(3'd6, 1'b1, 16'hFFFF, '0, 5'd31, "R4");
      run_op(3'd6, 1'b0, 16'h8000, 16'h0100, '0, "R4");
      run_op(3'd5, 1'b0, 16'h1234, 16'h0000, '0, "R4");
      // R5 compare outcomes, unsigned
      run_op(3'd7, 1'b0, 16'h1234, 16'h1234, '0, "R5");
      run_op(3'd7, 1'b0, 16'h8000, 16'h7FFF, '0, "R5");
      run_op(3'd7, 1'b0, 16'h0001, 16'hFFFF, '0, "R5");
      idle_cycle();
      idle_cycle();

      for (int i = 0; i < 600; i++) begin
         logic [2:0]    o;
         logic          s;
         logic [DW-1:0] a;
         logic [DW-1:0] b;
         o = 3'($urandom);
         s = 1'($urandom);
         a = 16'($urandom);
         b = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 20)) : 16'($urandom);
         if ($urandom_range(0, 7) == 0) b = a;
         run_op(o, s, a, b, 5'($urandom), tag_of(o));
         if ($urandom_range(0, 9) == 0) idle_cycle();
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule